// File: doc/BRIEF.md
# SPI Control Register Port with One-Time Mode Register

This block is the serial control port of a supply-management device. A host microcontroller reaches a small register map through fixed 16-bit SPI frames. Every frame is full duplex: while the host shifts a header and a 12-bit payload in, the block shifts a 12-bit feedback word out. A header bit picks which feedback word is returned. A read-only header bit lets the host read without writing anything.

The map has four addresses:
- Address 0 is a one-time special mode register. It can be written only by the first valid frame after power-on.
- Address 1 is a configuration register. Through it, software can clear the development-mode bit in the normal operating modes.
- Addresses 2 and 3 are two 12-bit general-purpose registers. They keep host data across host power cycles.

Register 2 comes out of power-on holding an identification code, with its top bit flagging that the code is still present. Both general-purpose registers are writable only in the start-up, restart and flash-programming modes.

The SPI pins are oversampled by a system clock. All state therefore lives in that one clock domain.

Top module: `sbc_spi_regfile`

## Requirements
- R1: A frame is 16 bits, sent MSB first while csN is low, with MOSI taken on rising SCK. Bits 15:14 are the address, bit 13 is the feedback select (fbSel), bit 12 is the read-only flag (rdOnly), and bits 11:0 are the payload.
- R2: If csN rises after any count of SCK rising edges other than 16, the frame is discarded. No register and no lock state changes.
- R3: After power-on reset, gp0Out = {1'b1, ID_CODE} with ID_CODE = 11'h2A5. Also gp1Out = 0, devModeOut = 0 and miso = 0.
- R4: MISO carries four 0 bits and then the 12-bit feedback word, MSB first, changing after falling SCK. The feedback word is built from register values captured when csN falls. With fbSel=0 it is the addressed register: addresses 0 and 1 give {11'b0, devMode}, address 2 gives gp0 and address 3 gives gp1. With fbSel=1 it is the status word: bits 11:9 hold the mode, bit 8 is 1 while the one-time window is open, bit 0 holds devMode, and all other bits are 0.
- R5: A valid frame with rdOnly=1 writes no register.
- R6: Mode codes are Start-up=0, Restart=1, Flash=2, Normal=3, Standby=4 and Sleep=5. A write to address 3 stores the payload only in modes 0, 1 and 2. A write to address 2 stores payload bits 10:0 and clears bit 11, again only in modes 0, 1 and 2. In every other mode these writes leave the registers unchanged.
- R7: The one-time window is open only from power-on until the first valid frame. A write to address 0 while the window is open sets devMode to payload bit 0. Any valid frame closes the window, and later writes to address 0 have no effect.
- R8: A write to address 1 with payload bit 0 = 0 clears devMode in modes 3 and 4. In any other case a write to address 1 has no effect.
- R9: Once gp0Out bit 11 is 0, it stays 0 until the next power-on reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the SPI pins |
| rstN | input | 1 | Power-on reset, active low, asynchronous |
| sck | input | 1 | SPI clock |
| csN | input | 1 | SPI chip select, active low |
| mosi | input | 1 | SPI serial data in |
| miso | output | 1 | SPI serial data out |
| opMode | input | 3 | Current operating mode code |
| gp0Out | output | 12 | General-purpose register 0 |
| gp1Out | output | 12 | General-purpose register 1 |
| devModeOut | output | 1 | Software-development-mode bit |

## Verification
Each SPI pin passes two synchronizer flops and one edge register. Because of this, MISO settles three system clocks after a falling SCK edge. The bench holds each SCK level for eight clocks and samples MISO on the last clock before it raises SCK. A commit lands three clocks after csN rises, and the bench checks the register outputs ten clocks after the rise, with all inputs driven on falling clock edges. A reference model in the bench predicts each feedback word from its state before the frame, then applies the write rules. It is exercised over every mode, address, fbSel and rdOnly combination, and also over frames that are too short or too long.

// File: rtl/sbc_spi_pkg.sv
package sbc_spi_pkg;

  typedef enum logic [2:0] {
    MODE_STARTUP = 3'd0,
    MODE_RESTART = 3'd1,
    MODE_FLASH   = 3'd2,
    MODE_NORMAL  = 3'd3,
    MODE_STANDBY = 3'd4,
    MODE_SLEEP   = 3'd5
  } opMode_e;

  typedef struct packed {
    logic capture;
    logic shiftIn;
    logic loadTx;
    logic shiftTx;
    logic clearOut;
    logic commit;
  } spiStrobes_t;

  function automatic logic gpWritable(input logic [2:0] mode);
    return (mode == MODE_STARTUP) || (mode == MODE_RESTART) || (mode == MODE_FLASH);
  endfunction

  function automatic logic devClearable(input logic [2:0] mode);
    return (mode == MODE_NORMAL) || (mode == MODE_STANDBY);
  endfunction

endpackage

// File: rtl/sbc_spi_ctl.sv
module sbc_spi_ctl
  import sbc_spi_pkg::*;
#(
  parameter int FRAME_W = 16,
  parameter int HDR_W   = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        sck,
  input  logic        csN,
  input  logic        mosi,
  output logic        mosiBit,
  output spiStrobes_t stb
);
  localparam int CNT_W = $clog2(FRAME_W) + 1;
  localparam logic [CNT_W-1:0] CNT_MAX  = '1;
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
  localparam logic [CNT_W-1:0] CNT_HDR  = CNT_W'(HDR_W);

  logic [2:0] sckS, csS;
  logic [1:0] mosiS;
  logic [CNT_W-1:0] bitCnt;
  logic sckRise, sckFall, csFall, csRise, csActive, outEdge;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sckS  <= '0;
      csS   <= '1;
      mosiS <= '0;
    end else begin
      sckS  <= {sckS[1:0], sck};
      csS   <= {csS[1:0], csN};
      mosiS <= {mosiS[0], mosi};
    end
  end

  assign sckRise  = sckS[1] & ~sckS[2];
  assign sckFall  = ~sckS[1] & sckS[2];
  assign csFall   = csS[2] & ~csS[1];
  assign csRise   = ~csS[2] & csS[1];
  assign csActive = ~csS[1];
  assign mosiBit  = mosiS[1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt <= '0;
    end else if (csFall) begin
      bitCnt <= '0;
    end else if (sckRise && csActive && bitCnt != CNT_MAX) begin
      bitCnt <= bitCnt + 1'b1;
    end
  end

  assign outEdge = sckFall & csActive;

  always_comb begin
    stb.capture  = csFall;
    stb.shiftIn  = sckRise & csActive;
    stb.loadTx   = outEdge && (bitCnt == CNT_HDR);
    stb.shiftTx  = outEdge && (bitCnt > CNT_HDR) && (bitCnt < CNT_FULL);
    stb.clearOut = outEdge && !stb.loadTx && !stb.shiftTx;
    stb.commit   = csRise && (bitCnt == CNT_FULL);
  end

endmodule

// File: rtl/sbc_spi_dp.sv
module sbc_spi_dp
  import sbc_spi_pkg::*;
#(
  parameter int GP_W    = 12,
  parameter int HDR_W   = 4,
  parameter logic [GP_W-2:0] ID_CODE = 11'h2A5
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        mosiBit,
  input  spiStrobes_t stb,
  input  logic [2:0]  opMode,
  output logic        miso,
  output logic [GP_W-1:0] gp0Out,
  output logic [GP_W-1:0] gp1Out,
  output logic        devModeOut,
  output logic        smOpen
);
  localparam int FRAME_W = GP_W + HDR_W;
  localparam int PAD_W   = GP_W - 5;

  logic [FRAME_W-1:0] rxReg;
  logic [GP_W-1:0] txReg, selWord, snapGp0, snapGp1;
  logic [2:0] snapMode;
  logic snapOpen, snapDev;
  logic [1:0] hdrAddr, cmtAddr;
  logic hdrSel, cmtRo;
  logic [GP_W-1:0] cmtData;

  assign hdrAddr = rxReg[HDR_W-1:HDR_W-2];
  assign hdrSel  = rxReg[HDR_W-3];
  assign cmtAddr = rxReg[FRAME_W-1:FRAME_W-2];
  assign cmtRo   = rxReg[FRAME_W-4];
  assign cmtData = rxReg[GP_W-1:0];

  always_comb begin
    if (hdrSel) begin
      selWord = {snapMode, snapOpen, {PAD_W{1'b0}}, snapDev};
    end else begin
      unique case (hdrAddr)
        2'd2:    selWord = snapGp0;
        2'd3:    selWord = snapGp1;
        default: selWord = {{(GP_W-1){1'b0}}, snapDev};
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxReg      <= '0;
      txReg      <= '0;
      miso       <= 1'b0;
      snapGp0    <= '0;
      snapGp1    <= '0;
      snapMode   <= '0;
      snapOpen   <= 1'b0;
      snapDev    <= 1'b0;
      gp0Out     <= {1'b1, ID_CODE};
      gp1Out     <= '0;
      devModeOut <= 1'b0;
      smOpen     <= 1'b1;
    end else begin
      if (stb.shiftIn) rxReg <= {rxReg[FRAME_W-2:0], mosiBit};

      if (stb.capture) begin
        snapGp0  <= gp0Out;
        snapGp1  <= gp1Out;
        snapMode <= opMode;
        snapOpen <= smOpen;
        snapDev  <= devModeOut;
        miso     <= 1'b0;
      end else if (stb.loadTx) begin
        miso  <= selWord[GP_W-1];
        txReg <= {selWord[GP_W-2:0], 1'b0};
      end else if (stb.shiftTx) begin
        miso  <= txReg[GP_W-1];
        txReg <= {txReg[GP_W-2:0], 1'b0};
      end else if (stb.clearOut) begin
        miso <= 1'b0;
      end

      if (stb.commit) begin
        smOpen <= 1'b0;
        if (!cmtRo) begin
          unique case (cmtAddr)
            2'd0: if (smOpen) devModeOut <= cmtData[0];
            2'd1: if (devClearable(opMode) && !cmtData[0]) devModeOut <= 1'b0;
            2'd2: if (gpWritable(opMode)) gp0Out <= {1'b0, cmtData[GP_W-2:0]};
            default: if (gpWritable(opMode)) gp1Out <= cmtData;
          endcase
        end
      end
    end
  end

endmodule

// File: rtl/sbc_spi_regfile.sv
module sbc_spi_regfile
  import sbc_spi_pkg::*;
#(
  parameter int GP_W  = 12,
  parameter int HDR_W = 4,
  parameter logic [GP_W-2:0] ID_CODE = 11'h2A5
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            sck,
  input  logic            csN,
  input  logic            mosi,
  output logic            miso,
  input  logic [2:0]      opMode,
  output logic [GP_W-1:0] gp0Out,
  output logic [GP_W-1:0] gp1Out,
  output logic            devModeOut
);
  localparam int FRAME_W = GP_W + HDR_W;

  spiStrobes_t stb;
  logic mosiBit;
  logic smOpen;

  sbc_spi_ctl #(.FRAME_W(FRAME_W), .HDR_W(HDR_W)) u_ctl (
    .clk(clk), .rstN(rstN), .sck(sck), .csN(csN), .mosi(mosi),
    .mosiBit(mosiBit), .stb(stb)
  );

  sbc_spi_dp #(.GP_W(GP_W), .HDR_W(HDR_W), .ID_CODE(ID_CODE)) u_dp (
    .clk(clk), .rstN(rstN), .mosiBit(mosiBit), .stb(stb), .opMode(opMode),
    .miso(miso), .gp0Out(gp0Out), .gp1Out(gp1Out), .devModeOut(devModeOut),
    .smOpen(smOpen)
  );

endmodule

// File: rtl/sbc_spi_regfile_chk.sv
module sbc_spi_regfile_chk
  import sbc_spi_pkg::*;
#(
  parameter int GP_W = 12
) (
  input logic            clk,
  input logic            rstN,
  input logic [2:0]      opMode,
  input logic            miso,
  input logic [GP_W-1:0] gp0Out,
  input logic [GP_W-1:0] gp1Out,
  input logic            devModeOut,
  input logic            smOpen,
  input spiStrobes_t     stb
);

  AST_GP1_MODE_GUARD: assert property (@(posedge clk) disable iff (!rstN)
    (gp1Out != $past(gp1Out)) |-> gpWritable($past(opMode))); // R6

  AST_NO_CHANGE_WITHOUT_COMMIT: assert property (@(posedge clk) disable iff (!rstN)
    ((gp0Out != $past(gp0Out)) || (devModeOut != $past(devModeOut))) |-> $past(stb.commit)); // R2

  AST_ID_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    !gp0Out[GP_W-1] |=> !gp0Out[GP_W-1]); // R9

  AST_DEV_SET_ONLY_OPEN: assert property (@(posedge clk) disable iff (!rstN)
    $rose(devModeOut) |-> $past(smOpen)); // R7

  AST_WINDOW_CLOSES: assert property (@(posedge clk) disable iff (!rstN)
    $past(stb.commit) |-> !smOpen); // R7

  AST_MISO_STABLE_AT_RISE: assert property (@(posedge clk) disable iff (!rstN)
    stb.shiftIn |=> $stable(miso)); // R4

endmodule

bind sbc_spi_regfile sbc_spi_regfile_chk #(.GP_W(GP_W)) u_chk (
  .clk(clk), .rstN(rstN), .opMode(opMode), .miso(miso), .gp0Out(gp0Out),
  .gp1Out(gp1Out), .devModeOut(devModeOut), .smOpen(smOpen), .stb(stb)
);

// File: tb/sbc_spi_regfile_bench.sv
module sbc_spi_regfile_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [10:0] ID = 11'h2A5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sck = 1'b0, csN = 1'b1, mosi = 1'b0;
  logic [2:0] opMode = 3'd0;
  logic miso, devModeOut;
  logic [11:0] gp0Out, gp1Out;

  int nChecks = 0, nFails = 0;
  bit done = 1'b0;

  logic [11:0] mGp0, mGp1;
  logic mDev, mOpen;

  always #(CLK_PERIOD/2) clk = ~clk;

  sbc_spi_regfile u_sbc_spi_regfile (
    .clk(clk), .rstN(rstN), .sck(sck), .csN(csN), .mosi(mosi), .miso(miso),
    .opMode(opMode), .gp0Out(gp0Out), .gp1Out(gp1Out), .devModeOut(devModeOut)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [11:0] fbWord(input logic [1:0] a, input logic sel);
    if (sel) return {opMode, mOpen, 7'b0, mDev};
    case (a)
      2'd2: return mGp0;
      2'd3: return mGp1;
      default: return {11'b0, mDev};
    endcase
  endfunction

  task automatic doFrame(input logic [1:0] a, input logic sel, input logic ro,
                         input logic [11:0] d, input int nbits, input string req);
    logic [15:0] w, rx, exp;
    w = {a, sel, ro, d};
    exp = {4'b0, fbWord(a, sel)};
    rx = '0;
    @(negedge clk) csN = 1'b0;
    for (int i = 0; i < nbits; i++) begin
      mosi = (i < 16) ? w[15-i] : 1'b0;
      repeat (8) @(negedge clk);
      if (i < 16) rx[15-i] = miso;
      sck = 1'b1;
      repeat (8) @(negedge clk);
      sck = 1'b0;
    end
    repeat (8) @(negedge clk);
    csN = 1'b1;
    repeat (10) @(negedge clk);
    if (nbits == 16) begin
      chk({req, " R4 readback"}, 32'(rx), 32'(exp));
      if (!ro) begin
        case (a)
          2'd0: if (mOpen) mDev = d[0];
          2'd1: if ((opMode == 3'd3 || opMode == 3'd4) && !d[0]) mDev = 1'b0;
          2'd2: if (opMode <= 3'd2) mGp0 = {1'b0, d[10:0]};
          default: if (opMode <= 3'd2) mGp1 = d;
        endcase
      end
      mOpen = 1'b0;
    end
    chk({req, " gp0"}, 32'(gp0Out), 32'(mGp0));
    chk({req, " gp1"}, 32'(gp1Out), 32'(mGp1));
    chk({req, " devMode"}, 32'(devModeOut), 32'(mDev));
  endtask

  initial begin
    mGp0 = {1'b1, ID}; mGp1 = '0; mDev = 1'b0; mOpen = 1'b1;
    repeat (3) @(negedge clk);
    chk("R3 miso at reset", 32'(miso), 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    chk("R3 gp0 reset", 32'(gp0Out), 32'({1'b1, ID}));
    chk("R3 gp1 reset", 32'(gp1Out), 0);
    chk("R3 devMode reset", 32'(devModeOut), 0);

    opMode = 3'd0;
    doFrame(2'd0, 1'b0, 1'b0, 12'h001, 15, "R2 short frame");
    doFrame(2'd3, 1'b0, 1'b0, 12'hABC, 17, "R2 long frame");
    doFrame(2'd0, 1'b1, 1'b0, 12'h001, 16, "R7 first access sets");
    doFrame(2'd0, 1'b0, 1'b0, 12'h000, 16, "R7 locked write ignored");
    opMode = 3'd3;
    doFrame(2'd1, 1'b1, 1'b0, 12'h001, 16, "R8 write one no effect");
    opMode = 3'd1;
    doFrame(2'd1, 1'b0, 1'b0, 12'h000, 16, "R8 wrong mode");
    opMode = 3'd4;
    doFrame(2'd1, 1'b1, 1'b0, 12'h000, 16, "R8 standby clear");
    opMode = 3'd2;
    doFrame(2'd3, 1'b0, 1'b1, 12'h5A5, 16, "R5 read-only gp1");
    doFrame(2'd2, 1'b0, 1'b0, 12'hFFF, 16, "R6 R1 gp0 write");
    chk("R9 id flag cleared", 32'(gp0Out[11]), 0);

    for (int m = 0; m < 6; m++) begin
      opMode = 3'(m);
      for (int ro = 0; ro < 2; ro++)
        for (int s = 0; s < 2; s++)
          for (int a = 0; a < 4; a++)
            doFrame(2'(a), 1'(s), 1'(ro),
                    12'((m * 733 + a * 151 + ro * 1187 + s * 59 + 17) & 12'hFFF),
                    16, "R1 R5 R6 sweep");
    end
    chk("R9 id flag stays low", 32'(gp0Out[11]), 0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

endmodule